// File: doc/BRIEF.md
# Two-Class Fair Bus Arbiter

This block decides which requester may drive a shared packet bus next. Every requester, whether a processor node or the host, raises a request while it holds a packet, and marks that packet as high or low class. The arbiter hands the bus to one requester at a time, for one whole fixed-length packet. It does not carry the data, the packets or the queues.

Each decision takes a short arbitration phase. The arbiter then asserts a one-hot grant for exactly one packet length of bus cycles. It flags the final word so that the data path can release the bus. When more requests are pending, the next arbitration follows at once, so back-to-back packets run at a fixed period. A low-class packet is held off while any high-class packet is waiting anywhere. A round-based fairness mask stops one requester from taking two slots before the others in the same class have had one.

Top module: `twoclass_bus_arb`

## Requirements
- R1: After reset, and whenever no request is present, `grant_o` is all zero and `busy_o` and `done_o` are low.
- R2: `grant_o` never has more than one bit set. Bit i grants requester i.
- R3: A requester whose pending packet is low class (`hi_i[i]`=0) is granted only when no requester has `req_i` and `hi_i` both set at the decision.
- R4: Within the class chosen at a decision, a requester that has already won in the current round is not granted again while another requester of that class that has not yet won is requesting. When no such requester remains, a new round starts and all requesters become eligible again.
- R5: Among eligible requesters, the first one in ascending index order, wrapping around, after the previous winner is chosen. After reset the search starts at index 0.
- R6: Each decision takes ARB_CYCLES (default 2) clock cycles. In back-to-back operation the new grant appears on the third cycle after the cycle in which `done_o` was high, which gives one packet every PKT_WORDS+ARB_CYCLES cycles.
- R7: A grant stays unchanged for exactly PKT_WORDS (default 32) cycles. `busy_o` is high exactly while a grant is asserted, and `done_o` is high only in the last word cycle of the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Per-requester packet pending |
| hi_i | input | N_REQ | Class of the pending packet, 1 = high |
| grant_o | output | N_REQ | One-hot bus grant |
| busy_o | output | 1 | A packet transfer is in progress |
| done_o | output | 1 | Last word of the current packet |

## Verification
A corrupted fairness mask or rotation pointer appears at the very next grant as the wrong requester index, because every decision is compared against a model of rounds and rotation. A stale class decision appears the same way, as a low-class winner while a high-class request is visible. A fault in the phase counter shows up within one packet: the grant holds for the wrong number of cycles, `done_o` lands on the wrong word, or the gap between back-to-back packets moves away from the expected three sampled cycles. Every combination of requesting set and class pattern over four requesters is swept, with two packets per requester in alternating classes.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_XFER = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_REQ = 4,
  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] cand_i,
  input  logic [IW-1:0]    ptr_i,
  output logic [N_REQ-1:0] win_o,
  output logic [IW-1:0]    win_idx_o,
  output logic             valid_o
);
  logic [IW:0] idx;

  // search starts one past the last winner
  always_comb begin
    win_o     = '0;
    win_idx_o = '0;
    valid_o   = 1'b0;
    idx       = '0;
    for (int k = 1; k <= N_REQ; k++) begin
      idx = {1'b0, ptr_i} + (IW+1)'(k);
      if (idx >= (IW+1)'(N_REQ)) idx = idx - (IW+1)'(N_REQ);
      if (!valid_o && cand_i[idx[IW-1:0]]) begin
        valid_o                = 1'b1;
        win_o[idx[IW-1:0]]     = 1'b1;
        win_idx_o              = idx[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/arb_pkt_timer.sv
module arb_pkt_timer
  import arb_pkg::*;
#(
  parameter int ARB_CYCLES = 2,
  parameter int PKT_WORDS  = 32,
  localparam int MAXC = (PKT_WORDS > ARB_CYCLES) ? PKT_WORDS : ARB_CYCLES,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_req_i,
  input  logic win_valid_i,
  output logic decide_o,
  output logic busy_o,
  output logic last_o
);
  arb_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign decide_o = (state_q == ST_ARB)  && (cnt_q == CW'(ARB_CYCLES - 1));
  assign last_o   = (state_q == ST_XFER) && (cnt_q == CW'(PKT_WORDS - 1));
  assign busy_o   = (state_q == ST_XFER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (any_req_i) state_q <= ST_ARB;
        end
        ST_ARB: begin
          if (decide_o) begin
            cnt_q   <= '0;
            state_q <= win_valid_i ? ST_XFER : ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (last_o) begin
            cnt_q   <= '0;
            state_q <= any_req_i ? ST_ARB : ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER) |-> (cnt_q < CW'(PKT_WORDS)));

  // R6
  arb_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARB) |-> (cnt_q < CW'(ARB_CYCLES)));
endmodule

// File: rtl/twoclass_bus_arb.sv
module twoclass_bus_arb #(
  parameter int N_REQ      = 9,
  parameter int PKT_WORDS  = 32,
  parameter int ARB_CYCLES = 2,
  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] hi_i,
  output logic [N_REQ-1:0] grant_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [N_REQ-1:0] grant_q, served_q;
  logic [IW-1:0]    ptr_q;
  logic [N_REQ-1:0] hi_req, cand, elig, pick_set, win;
  logic [IW-1:0]    win_idx;
  logic             any_hi, fresh, win_valid, decide, last;

  // low class locked out while any high request waits
  assign hi_req   = req_i & hi_i;
  assign any_hi   = |hi_req;
  assign cand     = any_hi ? hi_req : req_i;
  assign elig     = cand & ~served_q;
  assign fresh    = (elig == '0);
  assign pick_set = fresh ? cand : elig;

  arb_rr_pick #(.N_REQ(N_REQ)) i_pick (
    .cand_i    (pick_set),
    .ptr_i     (ptr_q),
    .win_o     (win),
    .win_idx_o (win_idx),
    .valid_o   (win_valid)
  );

  arb_pkt_timer #(.ARB_CYCLES(ARB_CYCLES), .PKT_WORDS(PKT_WORDS)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .any_req_i   (|req_i),
    .win_valid_i (win_valid),
    .decide_o    (decide),
    .busy_o      (busy_o),
    .last_o      (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= '0;
      served_q <= '0;
      ptr_q    <= IW'(N_REQ - 1);
    end else if (decide && win_valid) begin
      grant_q  <= win;
      served_q <= fresh ? win : (served_q | win);
      ptr_q    <= win_idx;
    end else if (last) begin
      grant_q  <= '0;
    end
  end

  assign grant_o = grant_q;
  assign done_o  = last;

  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R7
  busy_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (grant_o != '0));

  // R7
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(grant_o));

  // R7
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  // R3
  lo_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && win_valid && any_hi) |-> ((win & hi_i & req_i) != '0));

  // R4
  no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && win_valid && ((cand & ~served_q) != '0)) |-> ((win & served_q) == '0));
endmodule

// File: tb/test_twoclass_bus_arb.sv
`timescale 1ns/1ps
module test_twoclass_bus_arb;
  localparam int N = 4;
  localparam int W = 32;
  localparam int A = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] hi_i  = '0;
  logic [N-1:0] grant_o;
  logic busy_o, done_o;

  always #2.5 clk = ~clk;

  twoclass_bus_arb #(.N_REQ(N), .PKT_WORDS(W), .ARB_CYCLES(A)) i_twoclass_bus_arb (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .hi_i(hi_i),
    .grant_o(grant_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int pend[N];
  int sent[N];
  logic [N-1:0] base_hi;
  logic [N-1:0] m_served = '0;
  int m_ptr = N - 1;
  logic [N-1:0] prev_grant = '0;
  int word_cnt = 0, since_done = 0;
  bit b2b = 1'b0, wd = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void drive();
    for (int i = 0; i < N; i++) begin
      req_i[i] = (pend[i] > 0);
      hi_i[i]  = base_hi[i] ^ sent[i][0];
    end
  endfunction

  function automatic logic [N-1:0] model_pick();
    logic [N-1:0] c, e, w;
    c = ((req_i & hi_i) != '0) ? (req_i & hi_i) : req_i;
    e = c & ~m_served;
    if (e == '0) begin
      m_served = '0;
      e = c;
    end
    w = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (m_ptr + k) % N;
      if (w == '0 && e[idx]) begin
        w[idx] = 1'b1;
        m_ptr = idx;
      end
    end
    m_served = m_served | w;
    return w;
  endfunction

  task automatic step();
    logic [N-1:0] exp;
    @(negedge clk);
    cyc++;
    since_done++;
    if (cyc > 190000) wd = 1'b1;
    chk(busy_o == (grant_o != '0), "R7 busy follows grant", {31'd0, busy_o}, {31'd0, grant_o != '0});
    if (grant_o != '0 && prev_grant == '0) begin
      exp = model_pick();
      chk(grant_o == exp, "R4 R5 winner", grant_o, exp);
      chk($onehot(grant_o), "R2 one-hot", grant_o, exp);
      if ((grant_o & hi_i) == '0)
        chk((req_i & hi_i) == '0, "R3 low class lockout", req_i & hi_i, 0);
      if (b2b) chk(since_done == 3, "R6 arbitration gap", since_done, 3);
      b2b = 1'b0;
      word_cnt = 1;
    end else if (grant_o != '0) begin
      chk(grant_o == prev_grant, "R7 grant stable", grant_o, prev_grant);
      word_cnt++;
    end
    if (done_o) begin
      chk(word_cnt == W && grant_o != '0, "R7 packet length", word_cnt, W);
      for (int i = 0; i < N; i++)
        if (grant_o[i]) begin
          pend[i]--;
          sent[i]++;
        end
      drive();
      b2b = (req_i != '0);
      since_done = 0;
    end
    prev_grant = grant_o;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      pend[i] = 0;
      sent[i] = 0;
    end
    base_hi = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(grant_o == '0 && !busy_o && !done_o, "R1 reset outputs", {busy_o, done_o, grant_o}, 0);
    rst_ni = 1'b1;
    for (int c = 0; c < 8; c++) begin
      step();
      chk(grant_o == '0 && !busy_o && !done_o, "R1 idle without requests", {busy_o, done_o, grant_o}, 0);
    end
    for (int hm = 0; hm < (1 << N); hm++) begin
      for (int rm = 1; rm < (1 << N); rm++) begin
        bit all_zero;
        if (wd) break;
        base_hi = N'(hm);
        for (int i = 0; i < N; i++) begin
          pend[i] = rm[i] ? 2 : 0;
          sent[i] = 0;
        end
        drive();
        all_zero = 1'b0;
        while (!all_zero && !wd) begin
          step();
          all_zero = 1'b1;
          for (int i = 0; i < N; i++) if (pend[i] != 0) all_zero = 1'b0;
        end
        for (int c = 0; c < 4; c++) begin
          step();
          chk(grant_o == '0 && !busy_o, "R1 idle after drain", {busy_o, grant_o}, 0);
        end
      end
      if (wd) break;
    end
    if (wd) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule